// File: doc/BRIEF.md
# Microcoded Queue-Machine Sequencer

This block executes one 8-bit opcode at a time by stepping through a fixed list of sixteen 6-bit micro-ops. The opcode is read from a program memory at the address held in the program counter. It then indexes a microcode table whose 96-bit entries hold the sixteen micro-ops for that opcode. The datapath has no accumulator. It has a three-entry shift queue of 12-bit values. Every micro-op pushes exactly one value onto the head of the queue, and the oldest value falls off the tail.

A micro-op either copies a register onto the queue, writes the queue head back to a register, or pushes one of sixteen ALU results computed from the queue. Register operands are named by a 4-bit field. That field passes through a 16-entry translation table, which turns it into an index into a 256-entry register file of 12-bit words. The program counter is one of those register entries, so microcode advances it with ordinary load, increment and store micro-ops.

All four memories are filled through a single write port while the block is held in reset: the register file, the translation table, the microcode table and the program memory. Requests for outside service are signalled on a single trap output.

Top module: `qseq_core`

## Requirements
- R1: While `rst_n` is low, the three queue outputs, `step_o` and `opc_o` are zero and `trap_o` is low. On the first clock edge after release, the block fetches the opcode at the program-counter address and executes no micro-op. `step_o` stays 0 on that edge.
- R2: After that first fetch, `step_o` advances by one on every clock. It wraps from 15 to 0. On the edge that leaves step 15, the next opcode is fetched from the program memory at the program-counter value seen during step 15, before any write made by that step.
- R3: Step k executes the micro-op in bits [6k+5:6k] of the 96-bit microcode word, so the lowest six bits run first.
- R4: Every executed micro-op pushes one value onto the head (`q0_o`). The previous head moves to `q1_o` and the previous `q1_o` moves to `q2_o`.
- R5: A micro-op whose bits [5:4] are 2'b01 pushes register entry T[f]. Here f is bits [3:0] of the micro-op and T is the translation table.
- R6: A micro-op whose bits [5:4] are 2'b00 writes the current head into register entry T[f] and pushes the current head again.
- R7: A store to a register entry below 16 keeps only bits [3:0] of the head. The upper eight bits of that entry become zero.
- R8: A micro-op with bit 5 set pushes an ALU result. Let a, b and c be the head, second and third entries, m be bit 0, and fn be bits [4:1]. The result by fn is: 0 zero, 1 a or ~a when m=1, 2 b-a-m, 3 a+b+m, 4 a>>4, 5 a+1, 6 a+2, 7 the program counter's bits [11:8] above a[7:0], 8 a&b, 9 a|b, 10 a^b, 11 b, 12 a<<4, 13 c, 14 a[3:0], 15 one if a is zero, else zero. All results are taken modulo 2^12.
- R9: `trap_o` is high during an executing step exactly when its micro-op has bits 5, 4 and 1 set and bit 3 clear, and at least one of bit 2, bit 0 or `test_i` is high.
- R10: A write on the load port takes effect only while `rst_n` is low. `ld_tgt` selects the target: 0 selects the register file (address [7:0], data [11:0]). 1 selects the microcode table (address [7:0], data [95:0]). 2 selects the program memory (address [11:0], data [7:0]). 3 selects the translation table (address [3:0], data [7:0]). Writes while running have no effect.
- R11: The program counter is register entry 16 and is shown on `pc_o`. A store whose translated index is 16 changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; load window |
| ld_we | input | 1 | Load-port write strobe |
| ld_tgt | input | 2 | Load-port target memory select |
| ld_addr | input | 12 | Load-port address |
| ld_data | input | 96 | Load-port write data |
| test_i | input | 1 | Test flag that can qualify a trap |
| q0_o | output | 12 | Queue head |
| q1_o | output | 12 | Queue second entry |
| q2_o | output | 12 | Queue third entry |
| pc_o | output | 12 | Program counter (register entry 16) |
| step_o | output | 4 | Current micro-op step |
| opc_o | output | 8 | Opcode being executed |
| trap_o | output | 1 | Trap request for the current step |

## Verification
A bad micro-op selection or a bad ALU result reaches `q0_o` on the very edge that executes it, and reaches `q1_o` and `q2_o` on the following two edges. A corrupt register write or translation entry stays hidden until a later load pushes that entry, which can be many steps later. A wrong fetch address or opcode shows on `opc_o` at the wrap and changes the whole next sixteen-step trace. Comparing the queue, program counter, step and opcode against a behavioural model on every clock therefore exposes most faults within one instruction. Directed steps cover the general-register masking and the loads attempted while running, because those faults show only on a later read.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  localparam int unsigned DW     = 12;          // datapath and register width
  localparam int unsigned UW     = 6;           // micro-op width
  localparam int unsigned STEPS  = 16;          // micro-ops per opcode
  localparam int unsigned SW     = $clog2(STEPS);
  localparam int unsigned WORD_W = UW * STEPS;  // microcode word width
  localparam int unsigned OPW    = 8;           // opcode width
  localparam int unsigned FW     = 4;           // register field width
  localparam int unsigned NFLD   = 1 << FW;     // translation entries
  localparam int unsigned PCHW   = DW - 8;      // program-counter bits merged by fn 7

  typedef logic [DW-1:0] word_t;
  typedef logic [UW-1:0] uop_t;

  typedef enum logic [1:0] {
    LD_REGS  = 2'd0,
    LD_UCODE = 2'd1,
    LD_PROG  = 2'd2,
    LD_XLAT  = 2'd3
  } ld_tgt_e;

  typedef enum logic [1:0] {
    UC_STORE = 2'd0,
    UC_LOAD  = 2'd1,
    UC_ALU   = 2'd2
  } uclass_e;

  function automatic uclass_e uop_class(uop_t u);
    if (u[5])      return UC_ALU;
    else if (u[4]) return UC_LOAD;
    else           return UC_STORE;
  endfunction

  function automatic logic trap_hit(uop_t u, logic tst);
    return u[5] & u[4] & u[1] & ~u[3] & (u[2] | u[0] | tst);
  endfunction

  function automatic word_t alu_eval(logic [3:0] fn, logic m, word_t a, word_t b,
                                     word_t c, logic [PCHW-1:0] pc_hi);
    word_t r;
    case (fn)
      4'd0:    r = '0;
      4'd1:    r = m ? ~a : a;
      4'd2:    r = b - a - word_t'(m);
      4'd3:    r = a + b + word_t'(m);
      4'd4:    r = a >> 4;
      4'd5:    r = a + word_t'(1);
      4'd6:    r = a + word_t'(2);
      4'd7:    r = {pc_hi, a[7:0]};
      4'd8:    r = a & b;
      4'd9:    r = a | b;
      4'd10:   r = a ^ b;
      4'd11:   r = b;
      4'd12:   r = a << 4;
      4'd13:   r = c;
      4'd14:   r = word_t'(a[3:0]);
      default: r = word_t'(a == '0);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/qseq_regfile.sv
module qseq_regfile
  import qseq_pkg::*;
#(
  parameter int unsigned NREG   = 256,
  parameter int unsigned PC_IDX = 16,
  parameter int unsigned GP_N   = 16,
  parameter int unsigned GP_W   = 4,
  localparam int unsigned RAW   = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_we,
  input  logic [1:0]     ld_tgt,
  input  logic [RAW-1:0] ld_addr,
  input  word_t          ld_data,
  input  logic [FW-1:0]  fld_i,
  input  logic           st_we,
  input  word_t          st_val,
  output word_t          rd_val,
  output word_t          pc_val
);

  word_t          regs [NREG];
  logic [RAW-1:0] xlat [NFLD];
  logic [RAW-1:0] idx;
  logic           idx_gp;
  word_t          st_wdata;
  logic           ld_regs_acc;
  logic           ld_xlat_acc;

  assign idx         = xlat[fld_i];
  assign idx_gp      = idx < RAW'(GP_N);
  assign rd_val      = regs[idx];
  assign pc_val      = regs[PC_IDX];
  assign ld_regs_acc = !rst_n && ld_we && (ld_tgt == LD_REGS);
  assign ld_xlat_acc = !rst_n && ld_we && (ld_tgt == LD_XLAT);

  generate
    if (GP_W < DW) begin : g_trim
      assign st_wdata = idx_gp ? {{(DW-GP_W){1'b0}}, st_val[GP_W-1:0]} : st_val;
    end else begin : g_full
      assign st_wdata = st_val;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (ld_xlat_acc) xlat[ld_addr[FW-1:0]] <= ld_data[RAW-1:0];
  end

  always_ff @(posedge clk) begin
    if (ld_regs_acc)  regs[ld_addr] <= ld_data;
    else if (st_we)   regs[idx]     <= st_wdata;
  end

  // R7
  gp_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && idx_gp) |=> regs[$past(idx)][DW-1:GP_W] == '0);

  // R10
  run_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && ld_tgt == LD_REGS && !st_we) |=> regs[$past(ld_addr)] == $past(regs[ld_addr]));

endmodule

// File: rtl/qseq_ctrl.sv
module qseq_ctrl
  import qseq_pkg::*;
#(
  parameter int unsigned PROG_AW = 12,
  localparam int unsigned PDEPTH = 1 << PROG_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_we,
  input  logic [1:0]         ld_tgt,
  input  logic [PROG_AW-1:0] ld_addr,
  input  logic [WORD_W-1:0]  ld_data,
  input  logic [PROG_AW-1:0] pc_val,
  output uop_t               uop_o,
  output logic [SW-1:0]      step_o,
  output logic [OPW-1:0]     opc_o,
  output logic               exec_o
);

  logic [WORD_W-1:0] ucode [1 << OPW];
  logic [OPW-1:0]    prog  [PDEPTH];

  logic [WORD_W-1:0] uword_r;
  logic [SW-1:0]     step_r;
  logic [OPW-1:0]    opc_r;
  logic              primed_r;
  logic [OPW-1:0]    fetch_opc;
  logic [WORD_W-1:0] fetch_word;
  logic              wrap;

  assign fetch_opc  = prog[pc_val];
  assign fetch_word = ucode[fetch_opc];
  assign wrap       = primed_r && (step_r == SW'(STEPS-1));

  always_ff @(posedge clk) begin
    if (!rst_n && ld_we && ld_tgt == LD_UCODE) ucode[ld_addr[OPW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n && ld_we && ld_tgt == LD_PROG) prog[ld_addr] <= ld_data[OPW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_r <= 1'b0;
      step_r   <= '0;
      opc_r    <= '0;
      uword_r  <= '0;
    end else if (!primed_r) begin
      primed_r <= 1'b1;
      opc_r    <= fetch_opc;
      uword_r  <= fetch_word;
    end else begin
      step_r <= step_r + SW'(1);
      if (wrap) begin
        opc_r   <= fetch_opc;
        uword_r <= fetch_word;
      end else begin
        uword_r <= uword_r >> UW;
      end
    end
  end

  assign uop_o  = uword_r[UW-1:0];
  assign step_o = step_r;
  assign opc_o  = opc_r;
  assign exec_o = primed_r;

  // R1
  first_step_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed_r) |-> step_r == '0);

  // R2
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed_r |=> (step_r - $past(step_r)) == SW'(1));

  // R2
  wrap_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> opc_r == $past(fetch_opc));

endmodule

// File: rtl/qseq_queue.sv
module qseq_queue
  import qseq_pkg::*;
#(
  parameter int unsigned QD = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   exec_i,
  input  uop_t                   uop_i,
  input  word_t                  rd_val_i,
  input  logic [PCHW-1:0]        pc_hi_i,
  output logic [QD-1:0][DW-1:0]  q_o
);

  logic [QD-1:0][DW-1:0] q_r;
  word_t                 push_val;

  always_comb begin
    case (uop_class(uop_i))
      UC_ALU:  push_val = alu_eval(uop_i[4:1], uop_i[0], q_r[0], q_r[1], q_r[2], pc_hi_i);
      UC_LOAD: push_val = rd_val_i;
      default: push_val = q_r[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (exec_i) begin
      for (int i = QD - 1; i > 0; i--) q_r[i] <= q_r[i-1];
      q_r[0] <= push_val;
    end
  end

  assign q_o = q_r;

  // R4
  queue_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |=> (q_r[1] == $past(q_r[0])) && (q_r[2] == $past(q_r[1])));

  // R4
  queue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(q_r));

endmodule

// File: rtl/qseq_core.sv
module qseq_core
  import qseq_pkg::*;
#(
  parameter int unsigned PROG_AW = 12,
  parameter int unsigned NREG    = 256,
  parameter int unsigned PC_IDX  = 16,
  localparam int unsigned RAW    = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_we,
  input  logic [1:0]         ld_tgt,
  input  logic [PROG_AW-1:0] ld_addr,
  input  logic [WORD_W-1:0]  ld_data,
  input  logic               test_i,
  output logic [DW-1:0]      q0_o,
  output logic [DW-1:0]      q1_o,
  output logic [DW-1:0]      q2_o,
  output logic [DW-1:0]      pc_o,
  output logic [SW-1:0]      step_o,
  output logic [OPW-1:0]     opc_o,
  output logic               trap_o
);

  uop_t                 uop;
  logic                 exec;
  logic                 st_we;
  word_t                rd_val;
  word_t                pc_val;
  logic [2:0][DW-1:0]   q;

  assign st_we = exec && (uop_class(uop) == UC_STORE);

  qseq_ctrl #(.PROG_AW(PROG_AW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_we   (ld_we),
    .ld_tgt  (ld_tgt),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .pc_val  (pc_val[PROG_AW-1:0]),
    .uop_o   (uop),
    .step_o  (step_o),
    .opc_o   (opc_o),
    .exec_o  (exec)
  );

  qseq_regfile #(.NREG(NREG), .PC_IDX(PC_IDX)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_we   (ld_we),
    .ld_tgt  (ld_tgt),
    .ld_addr (ld_addr[RAW-1:0]),
    .ld_data (ld_data[DW-1:0]),
    .fld_i   (uop[FW-1:0]),
    .st_we   (st_we),
    .st_val  (q[0]),
    .rd_val  (rd_val),
    .pc_val  (pc_val)
  );

  qseq_queue #(.QD(3)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_i   (exec),
    .uop_i    (uop),
    .rd_val_i (rd_val),
    .pc_hi_i  (pc_val[DW-1:8]),
    .q_o      (q)
  );

  assign q0_o   = q[0];
  assign q1_o   = q[1];
  assign q2_o   = q[2];
  assign pc_o   = pc_val;
  assign trap_o = exec && trap_hit(uop, test_i);

  // R9
  trap_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (uop[5:4] == 2'b11) && !uop[3] && uop[1] && exec);

  // R6
  store_repush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> q0_o == $past(q0_o));

endmodule

// File: tb/tb_qseq_core.sv
module tb_qseq_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0;
  logic [1:0]  ld_tgt = 2'd0;
  logic [11:0] ld_addr = '0;
  logic [95:0] ld_data = '0;
  logic        test_i = 1'b0;
  logic [11:0] q0_o, q1_o, q2_o, pc_o;
  logic [3:0]  step_o;
  logic [7:0]  opc_o;
  logic        trap_o;

  always #10 clk = ~clk;

  qseq_core dut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_tgt(ld_tgt), .ld_addr(ld_addr),
    .ld_data(ld_data), .test_i(test_i), .q0_o(q0_o), .q1_o(q1_o), .q2_o(q2_o),
    .pc_o(pc_o), .step_o(step_o), .opc_o(opc_o), .trap_o(trap_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference state
  logic [11:0] mreg [256];
  logic [95:0] mu   [256];
  logic [7:0]  mrom [4096];
  logic [7:0]  mmap [16];
  int          mq [3];
  int          mstep;
  bit          mprimed;
  logic [7:0]  mop;
  logic [95:0] muw;

  task automatic chk(string req, string what, logic [95:0] act, logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] ref_alu(int f, int m, int a, int b, int c, int pch);
    int r;
    case (f)
      0: r = 0;
      1: r = (m != 0) ? (a ^ 'hFFF) : a;
      2: r = b - a - m;
      3: r = a + b + m;
      4: r = a / 16;
      5: r = a + 1;
      6: r = a + 2;
      7: r = pch * 256 + (a % 256);
      8: r = a & b;
      9: r = a | b;
      10: r = a ^ b;
      11: r = b;
      12: r = a * 16;
      13: r = c;
      14: r = a % 16;
      default: r = (a == 0) ? 1 : 0;
    endcase
    return r[11:0];
  endfunction

  function automatic bit ref_trap(logic [5:0] u, logic t);
    if (!mprimed) return 1'b0;
    if (u[5] != 1 || u[4] != 1 || u[3] != 0 || u[1] != 1) return 1'b0;
    return u[2] || u[0] || t;
  endfunction

  task automatic model_reset();
    mq[0] = 0; mq[1] = 0; mq[2] = 0;
    mstep = 0; mprimed = 0; mop = 0; muw = '0;
  endtask

  task automatic model_edge();
    logic [5:0]  u;
    logic [11:0] pcb, nv;
    logic [7:0]  idx;
    if (!mprimed) begin
      mop = mrom[mreg[16]];
      muw = mu[mop];
      mprimed = 1;
    end else begin
      u   = muw[5:0];
      pcb = mreg[16];
      idx = mmap[u[3:0]];
      if (u[5]) nv = ref_alu(int'(u[4:1]), int'(u[0]), mq[0], mq[1], mq[2], int'(pcb[11:8]));
      else if (u[4]) nv = mreg[idx];
      else begin
        nv = mq[0][11:0];
        mreg[idx] = (idx < 16) ? (nv & 12'h00F) : nv;
      end
      mq[2] = mq[1]; mq[1] = mq[0]; mq[0] = int'(nv);
      if (mstep == 15) begin
        mop = mrom[pcb];
        muw = mu[mop];
      end else begin
        muw = muw >> 6;
      end
      mstep = (mstep + 1) % 16;
    end
  endtask

  task automatic load(logic [1:0] tgt, int addr, logic [95:0] data);
    @(negedge clk);
    ld_we = 1'b1; ld_tgt = tgt; ld_addr = addr[11:0]; ld_data = data;
    @(posedge clk);
    case (tgt)
      2'd0: mreg[addr] = data[11:0];
      2'd1: mu[addr] = data;
      2'd2: mrom[addr] = data[7:0];
      default: mmap[addr] = data[7:0];
    endcase
  endtask

  task automatic end_load();
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic check_reset_state();
    chk("R1", "q0 in reset", q0_o, 0);
    chk("R1", "q1 in reset", q1_o, 0);
    chk("R1", "q2 in reset", q2_o, 0);
    chk("R1", "step in reset", step_o, 0);
    chk("R1", "opcode in reset", opc_o, 0);
    chk("R1", "trap in reset", trap_o, 0);
  endtask

  // one clock of running; noise>0 drives load-port writes that must be ignored
  task automatic cycle(int noise, bit rnd_test);
    test_i = rnd_test ? 1'($urandom) : 1'b0;
    if (noise == 1) begin
      ld_we = 1'($urandom); ld_tgt = 2'($urandom); ld_addr = 12'($urandom);
      ld_data = {$urandom, $urandom, $urandom};
    end else if (noise == 2) begin
      ld_we = 1'b1; ld_tgt = 2'd0; ld_addr = 12'd32; ld_data = 96'hABC;
    end else begin
      ld_we = 1'b0;
    end
    #1;
    chk("R9", "trap", trap_o, ref_trap(muw[5:0], test_i));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R3 R4 R5 R6 R8", "q0", q0_o, mq[0]);
    chk("R4", "q1", q1_o, mq[1]);
    chk("R4", "q2", q2_o, mq[2]);
    chk("R11", "pc", pc_o, mreg[16]);
    chk("R2", "step", step_o, mstep);
    chk("R2", "opcode", opc_o, mop);
  endtask

  initial begin
    logic [95:0] w;
    logic [5:0]  seq [16];
    model_reset();

    // ---------- random contents ----------
    #5;
    check_reset_state();
    for (int i = 0; i < 256; i++) load(2'd0, i, 96'($urandom));
    load(2'd0, 16, 96'd0);
    for (int i = 0; i < 256; i++) load(2'd1, i, {$urandom, $urandom, $urandom});
    for (int i = 0; i < 4096; i++) load(2'd2, i, 96'($urandom));
    for (int i = 0; i < 16; i++) load(2'd3, i, 96'($urandom));
    load(2'd3, 15, 96'd16);
    end_load();
    check_reset_state();
    rst_n = 1'b1;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R1", "no step on first edge", step_o, 0);
    chk("R1", "queue idle on first edge", q0_o, 0);
    chk("R1", "first fetch", opc_o, mrom[mreg[16]]);
    for (int n = 0; n < 3000; n++) cycle(1, 1'b1);

    // ---------- reset mid-run, directed contents ----------
    ld_we = 1'b0;
    rst_n = 1'b0;
    #1;
    model_reset();
    check_reset_state();
    for (int f = 0; f < 16; f++) load(2'd3, f, (f < 2) ? 96'(f) : (f == 15) ? 96'd16 : 96'(f * 16));
    for (int i = 0; i < 256; i++) load(2'd0, i, 96'd0);
    load(2'd0, 32, 96'h123);
    load(2'd0, 48, 96'h0F0);
    for (int i = 0; i < 4096; i++) load(2'd2, i, 96'd0);
    seq[0] = 6'b010010;  seq[1] = 6'b010011;  seq[2] = 6'b100110;  seq[3] = 6'b000000;
    seq[4] = 6'b010000;  seq[5] = 6'b010010;  seq[6] = 6'b101000;  seq[7] = 6'b101010;
    seq[8] = 6'b100011;  seq[9] = 6'b110011;  seq[10] = 6'b011111; seq[11] = 6'b101010;
    seq[12] = 6'b001111; seq[13] = 6'b100000; seq[14] = 6'b100000; seq[15] = 6'b100000;
    w = '0;
    for (int k = 0; k < 16; k++) w[6*k +: 6] = seq[k];
    load(2'd1, 0, w);
    end_load();
    check_reset_state();
    rst_n = 1'b1;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    for (int n = 2; n <= 34; n++) begin
      cycle(2, 1'b0);
      if (n == 4)  chk("R8", "add of two loaded registers", q0_o, 12'h213);
      if (n == 6)  chk("R7", "general register keeps low nibble", q0_o, 12'h003);
      if (n == 8)  chk("R8", "shift right by four", q0_o, 12'h012);
      if (n == 10) chk("R8", "inverted head", q0_o, 12'hFEC);
      if (n == 10) chk("R9", "trap on marked op", trap_o, 1'b1);
      if (n == 11) chk("R8", "or result", q0_o, 12'hFFF);
      if (n == 14) chk("R11", "pc advanced by store", pc_o, 12'h001);
      if (n == 17) chk("R2", "wrap to step zero", step_o, 4'd0);
      if (n == 18) chk("R10", "register write while running ignored", q0_o, 12'h123);
      if (n == 30) chk("R11", "pc after second opcode", pc_o, 12'h002);
    end
    ld_we = 1'b0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule